// File: doc/BRIEF.md
# Context Slot Directory

This block keeps a directory of 64 on-chip register-context slots. Each slot carries a thread-handle tag and a valid bit. When the processor switches to a thread, it presents the thread's handle as a lookup. The directory then reports whether a resident slot already holds that thread, and gives that slot's index. A hit means the switch only has to change the register-set selection, and no memory traffic is needed.

On a miss, the directory names a victim slot. A programmable count of low slots is pinned: these slots are never named as victims. The victim is drawn pseudo-randomly from the slots above the pinned ones. Software claims the chosen slot with a tag write after it has moved the register contents. The register file itself, and the saving and restoring of register contents, happen outside this block.

Control is a two-state machine.
- **ST_IDLE** means no response is being presented this cycle.
- **ST_RESP** means the registered answer to the previous cycle's request is on the outputs, and `done` is high.

The transitions are:
- **go_resp**: ST_IDLE to ST_RESP, taken on a request.
- **chain**: ST_RESP to ST_RESP, taken on another request.
- **drop**: ST_RESP to ST_IDLE, taken when no request arrives.
- **stay**: ST_IDLE to ST_IDLE, taken when no request arrives.

Top module: `ctx_slot_dir`

## Requirements
- R1: After reset, every slot is invalid, the pinned count reads 0, and `done`, `hit` and `no_victim` are low.
- R2: `done` is high exactly in the cycle after a cycle with `lookup_req` high. Requests on consecutive cycles are each answered on the following cycle.
- R3: A lookup hits when some valid slot's tag equals `lookup_handle`. `hit_slot` then gives that slot's index.
- R4: When several valid slots carry the requested handle, `hit_slot` is the highest matching index. The scan runs from 63 down to 0, and the first match wins.
- R5: A slot written with `tag_valid` = 0 never produces a hit, whatever tag it holds.
- R6: A lookup compares against the tags as they stood before any tag write in the same cycle. A write changes the result of later lookups only.
- R7: On a miss with pinned count W below 64, `victim_slot` lies in [W, 63]. With W = 63, the victim is always 63.
- R8: On a miss with W of 64 or more, `no_victim` is high and `victim_slot` is 0. On a hit, `no_victim` is low and `victim_slot` is 0.
- R9: `hit`, `hit_slot`, `victim_slot` and `no_victim` hold their values until the next request is answered, including across tag and pinned-count writes.
- R10: `wired_count` reads back the last value written through `wired_we` from the following cycle on. A lookup in the same cycle as a write uses the previous pinned count.
- R11: The victim is taken from a 16-bit maximal-length pseudo-random sequence that advances on every clock: wired + (random mod (64 − wired)). Repeated misses therefore spread over all unpinned slots. With W = 60, all of slots 60 to 63 appear within 64 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_req | input | 1 | Start a lookup this cycle |
| lookup_handle | input | 16 | Thread handle to search for |
| tag_we | input | 1 | Write one slot's tag |
| tag_slot | input | 6 | Slot index for the tag write |
| tag_handle | input | 16 | Handle stored by the tag write |
| tag_valid | input | 1 | Valid bit stored by the tag write |
| wired_we | input | 1 | Write the pinned-slot count |
| wired_count_in | input | 7 | New pinned-slot count |
| wired_count | output | 7 | Current pinned-slot count |
| done | output | 1 | Response valid (cycle after request) |
| hit | output | 1 | A resident slot holds the handle |
| hit_slot | output | 6 | Index of the matching slot |
| victim_slot | output | 6 | Slot to evict on a miss |
| no_victim | output | 1 | Miss with every slot pinned |

## Verification
The bench tags all 64 slots with distinct handles and checks that each one is found at its own index. It then plants duplicate handles at a low and a high index. A design that scans upward would report the low slot.

The bench clears a slot's valid bit in the same cycle as a lookup of that slot's handle. A design that forwards the write would miss where it should hit. The same cycle-ordering trap is set for the pinned count.

Finally, the bench sweeps the pinned count from 0 through 64 and checks that each victim lies in range. At 63 and 64 the answer is exact. A design whose modulo or offset is off by one would evict a pinned slot or run past 63.

// File: rtl/ctx_dir_pkg.sv
package ctx_dir_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } dir_state_e;
endpackage

// File: rtl/ctx_tag_store.sv
module ctx_tag_store #(
    parameter int SLOTS    = 64,
    parameter int HANDLE_W = 16,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SLOT_W-1:0]                 wr_slot,
    input  logic [HANDLE_W-1:0]               wr_handle,
    input  logic                              wr_valid,
    output logic [SLOTS-1:0]                  valid_vec,
    output logic [SLOTS-1:0][HANDLE_W-1:0]    handle_arr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec  <= '0;
            handle_arr <= '0;
        end else if (wr_en) begin
            valid_vec[wr_slot]  <= wr_valid;
            handle_arr[wr_slot] <= wr_handle;
        end
    end

    // R1
    reset_invalid_chk: assert property (@(posedge clk)
        !rst_n |=> valid_vec == '0);
endmodule

// File: rtl/ctx_match_scan.sv
module ctx_match_scan #(
    parameter int SLOTS    = 64,
    parameter int HANDLE_W = 16,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]                  valid_vec,
    input  logic [SLOTS-1:0][HANDLE_W-1:0]    handle_arr,
    input  logic [HANDLE_W-1:0]               key,
    output logic                              found,
    output logic [SLOT_W-1:0]                 idx
);
    logic [SLOTS-1:0] eq_vec;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign eq_vec[g] = valid_vec[g] && (handle_arr[g] == key);
    end

    // Ascending walk: a later (higher) match overwrites, so the top index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (eq_vec[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/ctx_lfsr.sv
module ctx_lfsr #(
    parameter int              RND_W = 16,
    parameter logic [RND_W-1:0] TAPS = 16'hB400,
    parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd
);
    logic fb;
    assign fb = ^(rnd & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) rnd <= SEED;
        else        rnd <= {rnd[RND_W-2:0], fb};
    end

    // R11
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0 |=> rnd != '0);
endmodule

// File: rtl/ctx_victim_pick.sv
module ctx_victim_pick #(
    parameter int SLOTS    = 64,
    parameter int RND_W    = 16,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int WIRED_W = SLOT_W + 1
) (
    input  logic [RND_W-1:0]   rnd,
    input  logic [WIRED_W-1:0] wired,
    output logic [SLOT_W-1:0]  victim,
    output logic               none
);
    logic [RND_W-1:0] span;
    logic [RND_W-1:0] rem;
    logic [RND_W-1:0] sum;

    always_comb begin
        none   = (wired >= WIRED_W'(SLOTS));
        span   = none ? RND_W'(1) : (RND_W'(SLOTS) - RND_W'(wired));
        rem    = rnd % span;
        sum    = rem + RND_W'(wired);
        victim = none ? '0 : sum[SLOT_W-1:0];
    end
endmodule

// File: rtl/ctx_slot_dir.sv
module ctx_slot_dir
    import ctx_dir_pkg::*;
#(
    parameter int SLOTS    = 64,
    parameter int HANDLE_W = 16,
    parameter int RND_W    = 16,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int WIRED_W = SLOT_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lookup_req,
    input  logic [HANDLE_W-1:0] lookup_handle,
    input  logic                tag_we,
    input  logic [SLOT_W-1:0]   tag_slot,
    input  logic [HANDLE_W-1:0] tag_handle,
    input  logic                tag_valid,
    input  logic                wired_we,
    input  logic [WIRED_W-1:0]  wired_count_in,
    output logic [WIRED_W-1:0]  wired_count,
    output logic                done,
    output logic                hit,
    output logic [SLOT_W-1:0]   hit_slot,
    output logic [SLOT_W-1:0]   victim_slot,
    output logic                no_victim
);
    dir_state_e state_q, state_d;

    logic [SLOTS-1:0]               valid_vec;
    logic [SLOTS-1:0][HANDLE_W-1:0] handle_arr;
    logic                           m_found;
    logic [SLOT_W-1:0]              m_idx;
    logic [RND_W-1:0]               rnd;
    logic [SLOT_W-1:0]              v_idx;
    logic                           v_none;
    logic [WIRED_W-1:0]             wired_q;

    ctx_tag_store #(.SLOTS(SLOTS), .HANDLE_W(HANDLE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tag_we), .wr_slot(tag_slot), .wr_handle(tag_handle), .wr_valid(tag_valid),
        .valid_vec(valid_vec), .handle_arr(handle_arr)
    );

    ctx_match_scan #(.SLOTS(SLOTS), .HANDLE_W(HANDLE_W)) u_scan (
        .valid_vec(valid_vec), .handle_arr(handle_arr), .key(lookup_handle),
        .found(m_found), .idx(m_idx)
    );

    ctx_lfsr #(.RND_W(RND_W)) u_rnd (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    ctx_victim_pick #(.SLOTS(SLOTS), .RND_W(RND_W)) u_pick (
        .rnd(rnd), .wired(wired_q), .victim(v_idx), .none(v_none)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) wired_q <= '0;
        else if (wired_we) wired_q <= wired_count_in;
    end
    assign wired_count = wired_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = lookup_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = lookup_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers: captured on the request cycle, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit         <= 1'b0;
            hit_slot    <= '0;
            victim_slot <= '0;
            no_victim   <= 1'b0;
        end else if (lookup_req) begin
            hit         <= m_found;
            hit_slot    <= m_found ? m_idx : '0;
            victim_slot <= m_found ? '0 : v_idx;
            no_victim   <= m_found ? 1'b0 : v_none;
        end
    end

    assign done = (state_q == ST_RESP);

    // R2
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_req |=> done);
    // R2
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_req |=> !done);
    // R7
    victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit && !no_victim) |-> ({1'b0, victim_slot} >= $past(wired_q)));
    // R8
    no_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (no_victim == ($past(wired_q) >= WIRED_W'(SLOTS))));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_req |=> $stable({hit, hit_slot, victim_slot, no_victim}));
endmodule

// File: tb/ctx_slot_dir_tb_top.sv
module ctx_slot_dir_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lookup_req;
    logic [15:0] lookup_handle;
    logic        tag_we;
    logic [5:0]  tag_slot;
    logic [15:0] tag_handle;
    logic        tag_valid;
    logic        wired_we;
    logic [6:0]  wired_count_in;
    logic [6:0]  wired_count;
    logic        done;
    logic        hit;
    logic [5:0]  hit_slot;
    logic [5:0]  victim_slot;
    logic        no_victim;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_slot_dir dut_i (
        .clk(clk), .rst_n(rst_n),
        .lookup_req(lookup_req), .lookup_handle(lookup_handle),
        .tag_we(tag_we), .tag_slot(tag_slot), .tag_handle(tag_handle), .tag_valid(tag_valid),
        .wired_we(wired_we), .wired_count_in(wired_count_in), .wired_count(wired_count),
        .done(done), .hit(hit), .hit_slot(hit_slot),
        .victim_slot(victim_slot), .no_victim(no_victim)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_tag(input int slot, input int h, input bit v);
        @(negedge clk);
        tag_we = 1'b1; tag_slot = 6'(slot); tag_handle = 16'(h); tag_valid = v;
        @(negedge clk);
        tag_we = 1'b0;
    endtask

    task automatic set_wired(input int w);
        @(negedge clk);
        wired_we = 1'b1; wired_count_in = 7'(w);
        @(negedge clk);
        wired_we = 1'b0;
    endtask

    // Request on one negedge; response sampled on the next negedge.
    task automatic lookup(input int h);
        @(negedge clk);
        lookup_req = 1'b1; lookup_handle = 16'(h);
        @(negedge clk);
        lookup_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit [5:0] h1, v1;
        bit       b1;
        rst_n = 1'b0; lookup_req = 0; lookup_handle = 0;
        tag_we = 0; tag_slot = 0; tag_handle = 0; tag_valid = 0;
        wired_we = 0; wired_count_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(wired_count == 0, "R1 wired", wired_count, 0);
        check(!done && !hit && !no_victim, "R1 flags", {done, hit, no_victim}, 0);
        lookup(16'h0000);
        check(done, "R2 done", done, 1);
        check(!hit, "R1 no valid slot", hit, 0);
        @(negedge clk);
        check(!done, "R2 done drops", done, 1'b0);

        // R3 each slot found at its own index
        for (int i = 0; i < 64; i++) write_tag(i, 16'h1000 + i, 1'b1);
        for (int i = 0; i < 64; i++) begin
            lookup(16'h1000 + i);
            check(done && hit && hit_slot == 6'(i), "R3 hit slot", hit_slot, i);
            check(victim_slot == 0 && !no_victim, "R8 hit victim", victim_slot, 0);
        end

        // R2 back-to-back requests
        @(negedge clk);
        lookup_req = 1'b1; lookup_handle = 16'h1005;
        @(negedge clk);
        lookup_handle = 16'h1030;
        check(done && hit && hit_slot == 5, "R2 first of pair", hit_slot, 5);
        @(negedge clk);
        lookup_req = 1'b0;
        check(done && hit && hit_slot == 48, "R2 second of pair", hit_slot, 48);

        // R4 duplicates: highest index wins
        write_tag(5, 16'h7777, 1'b1);
        write_tag(40, 16'h7777, 1'b1);
        lookup(16'h7777);
        check(hit && hit_slot == 40, "R4 highest match", hit_slot, 40);
        write_tag(40, 16'h7777, 1'b0);
        // R5 invalidated slot no longer matches
        lookup(16'h7777);
        check(hit && hit_slot == 5, "R5 invalid skipped", hit_slot, 5);

        // R6 same-cycle write does not affect this lookup
        @(negedge clk);
        lookup_req = 1'b1; lookup_handle = 16'h7777;
        tag_we = 1'b1; tag_slot = 6'd5; tag_handle = 16'h7777; tag_valid = 1'b0;
        @(negedge clk);
        lookup_req = 1'b0; tag_we = 1'b0;
        check(hit && hit_slot == 5, "R6 old tags used", hit, 1);
        lookup(16'h7777);
        check(!hit, "R5 all copies invalid", hit, 0);

        // R9 hold across writes and idle cycles
        h1 = victim_slot; b1 = no_victim;
        write_tag(12, 16'h7777, 1'b1);
        set_wired(64);
        repeat (3) @(negedge clk);
        check(!hit && victim_slot == h1 && no_victim == b1, "R9 held", victim_slot, h1);
        check(!done, "R9 no done", done, 0);
        write_tag(12, 16'h100C, 1'b1);

        // R10 same-cycle wired write uses previous count
        check(wired_count == 64, "R10 readback", wired_count, 64);
        @(negedge clk);
        lookup_req = 1'b1; lookup_handle = 16'hBEEF;
        wired_we = 1'b1; wired_count_in = 7'd0;
        @(negedge clk);
        lookup_req = 1'b0; wired_we = 1'b0;
        check(no_victim && victim_slot == 0, "R10 old count / R8", no_victim, 1);
        check(wired_count == 0, "R10 readback new", wired_count, 0);

        // R7/R8 sweep of the pinned count
        for (int w = 0; w <= 66; w++) begin
            set_wired(w);
            for (int k = 0; k < 6; k++) begin
                lookup(16'hBEEF);
                if (w >= 64) begin
                    check(no_victim && victim_slot == 0, "R8 all pinned", victim_slot, 0);
                end else if (w == 63) begin
                    check(!no_victim && victim_slot == 63, "R7 only slot 63", victim_slot, 63);
                end else begin
                    check(!hit && !no_victim && int'(victim_slot) >= w,
                          "R7 victim range", victim_slot, w);
                end
            end
        end

        // R11 spread over unpinned slots
        set_wired(60);
        begin
            bit [3:0] seen = '0;
            for (int k = 0; k < 64; k++) begin
                lookup(16'hBEEF);
                v1 = victim_slot;
                if (v1 >= 60) seen[v1 - 60] = 1'b1;
            end
            check(seen == 4'hF, "R11 spread", seen, 15);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule